// File: doc/BRIEF.md
# Paged Address Translator with Lookaside Buffer

This block turns a logical address into a physical one using fixed-size pages. The low `OFF_W` bits of the address are the offset within a page and pass through unchanged. The bits above them are the page number, which selects a frame number. The frame number and the offset together form the physical address.

A small fully associative buffer of recent translations is searched first, with every entry compared in the same cycle. When the page is not in the buffer, the block issues a read of that page's table entry on a request/response port. It then writes the returned entry into the buffer and finishes the translation. Each table entry carries read, write, execute and valid permission bits, and an access that those bits do not allow ends with a fault. A flush input empties the buffer; it is used when the table contents or its location change.

Top module: `page_xlate`

## Requirements
- R1: A permitted access to logical address `{page, off}` returns physical address `{frame, off}`. For example, pages 0, 1, 2, 3 mapped to frames 5, 6, 1, 2 give frame 5, 6, 1, 2 respectively, and the offset is preserved unchanged.
- R2: On a buffer miss the block raises `pt_req` with `pt_page` equal to the requested page number. It holds both until `pt_rsp_valid`. It then pulses `done` in the following cycle and drops `pt_req`.
- R3: On a buffer hit, `done` rises in the cycle after the request is accepted, and no table read is issued.
- R4: A table entry is `{frame, v, x, w, r}`, with r in bit 0, w in bit 1, x in bit 2 and v in bit 3. Any access to an entry whose v bit is 0 faults.
- R5: A write (`req_acc` = 01) to an entry with w = 0 faults; a write with w = 1 does not.
- R6: A read (`req_acc` = 00 or 11) faults when r = 0. An instruction fetch (`req_acc` = 10) faults when x = 0.
- R7: When `done` comes with `fault` = 1, `pa_ok` is 0 and `paddr` is 0.
- R8: An entry that causes a fault is still installed in the buffer, so the next access to that page hits and faults without a table read.
- R9: A refill goes into the lowest free buffer entry. Once every entry is occupied, refills replace entries in round-robin order starting at entry 0.
- R10: A `flush` pulse invalidates every buffer entry, so the next access to any page misses.
- R11: A request presented while a miss is pending (`busy` = 1) is ignored. It produces no extra `done` and no table read.
- R12: After reset, `done`, `pa_ok`, `busy` and `pt_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request (accepted when not busy) |
| req_vaddr | input | VA_W | Logical address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 read |
| busy | output | 1 | A miss is waiting for the table response |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a permission or validity fault |
| pa_ok | output | 1 | Physical address is valid (done without fault) |
| paddr | output | PA_W | Physical address |
| pt_req | output | 1 | Table entry read request |
| pt_page | output | VA_W-OFF_W | Page number to read |
| pt_rsp_valid | input | 1 | Table response valid |
| pt_rsp_pte | input | PA_W-OFF_W+4 | Table entry `{frame, v, x, w, r}` |

## Verification
The assertions rely on two properties of the table port. First, `pt_rsp_valid` comes only while `pt_req` is high. Second, it lasts a single cycle. The bench's responder waits two cycles after seeing a request and then drives the response for exactly one cycle. The assertions also assume that requests are single-cycle pulses issued only after the previous `done`; the busy-overlap scenario is the one deliberate exception. The bench's driving tasks follow this rule, and the overlap case checks at the ports that the extra pulse has no effect.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W    = 20,
  parameter int PA_W    = 20,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_acc,
  output logic                      busy,
  output logic                      done,
  output logic                      fault,
  output logic                      pa_ok,
  output logic [PA_W-1:0]           paddr,
  output logic                      pt_req,
  output logic [VA_W-OFF_W-1:0]     pt_page,
  input  logic                      pt_rsp_valid,
  input  logic [PA_W-OFF_W+3:0]     pt_rsp_pte
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_vld;
  logic [VPN_W-1:0]   e_tag  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [3:0]         e_perm [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic               waiting;
  logic [OFF_W-1:0]   w_off;
  logic [1:0]         w_acc;

  wire [VPN_W-1:0] vpn = req_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] off = req_vaddr[OFF_W-1:0];

  function automatic logic denied(input logic [3:0] p, input logic [1:0] acc);
    // p = {v, x, w, r}
    return !p[3] || (acc == 2'b01 && !p[1]) || (acc == 2'b10 && !p[2]) ||
           ((acc == 2'b00 || acc == 2'b11) && !p[0]);
  endfunction

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_vld[g] && (e_tag[g] == vpn) && !flush;
  end

  logic             hit, any_free;
  logic [IDX_W-1:0] hit_idx, free_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    any_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && match[i]) begin
        hit = 1'b1;
        hit_idx = i[IDX_W-1:0];
      end
      if (!any_free && !e_vld[i]) begin
        any_free = 1'b1;
        free_idx = i[IDX_W-1:0];
      end
    end
  end

  wire [IDX_W-1:0] vict   = any_free ? free_idx : rr;
  wire [PFN_W-1:0] r_pfn  = pt_rsp_pte[PFN_W+3:4];
  wire [3:0]       r_perm = pt_rsp_pte[3:0];
  wire             h_bad  = denied(e_perm[hit_idx], req_acc);
  wire             r_bad  = denied(r_perm, w_acc);

  assign busy  = waiting;
  assign pa_ok = done && !fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld   <= '0;
      rr      <= '0;
      waiting <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      paddr   <= '0;
      pt_req  <= 1'b0;
      pt_page <= '0;
      w_off   <= '0;
      w_acc   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_tag[i]  <= '0;
        e_pfn[i]  <= '0;
        e_perm[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (!waiting) begin
        if (req_valid) begin
          if (hit) begin
            done  <= 1'b1;
            fault <= h_bad;
            paddr <= h_bad ? '0 : {e_pfn[hit_idx], off};
          end else begin
            waiting <= 1'b1;
            pt_req  <= 1'b1;
            pt_page <= vpn;
            w_off   <= off;
            w_acc   <= req_acc;
          end
        end
      end else if (pt_rsp_valid) begin
        e_vld[vict]  <= 1'b1;
        e_tag[vict]  <= pt_page;
        e_pfn[vict]  <= r_pfn;
        e_perm[vict] <= r_perm;
        if (!any_free)
          rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
        waiting <= 1'b0;
        pt_req  <= 1'b0;
        done    <= 1'b1;
        fault   <= r_bad;
        paddr   <= r_bad ? '0 : {r_pfn, w_off};
      end
      if (flush) e_vld <= '0;
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int PA_W  = 20,
  parameter int VPN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [PA_W-1:0]  paddr,
  input logic             pt_req,
  input logic [VPN_W-1:0] pt_page,
  input logic             pt_rsp_valid
);
  // R2
  pt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req && !pt_rsp_valid |=> pt_req && $stable(pt_page));
  // R2
  rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pt_rsp_valid |=> done && !busy && !pt_req);
  // R3
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> done || pt_req);
  // R7
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault && done |-> paddr == '0);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pt_req);
endmodule

bind page_xlate page_xlate_chk #(.PA_W(PA_W), .VPN_W(VA_W - OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .fault(fault), .paddr(paddr), .pt_req(pt_req), .pt_page(pt_page),
  .pt_rsp_valid(pt_rsp_valid));

// File: tb/tb_page_xlate.sv
module tb_page_xlate;
  localparam int CLK_P = 10;
  localparam int VA_W = 20, PA_W = 20, OFF_W = 12, ENTRIES = 4;
  localparam int VPN_W = VA_W - OFF_W, PFN_W = PA_W - OFF_W;

  logic clk = 0, rst_n = 0, flush = 0, req_valid = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_acc = '0;
  logic busy, done, fault, pa_ok, pt_req, pt_rsp_valid = 0;
  logic [PA_W-1:0] paddr;
  logic [VPN_W-1:0] pt_page;
  logic [PFN_W+3:0] pt_rsp_pte = '0;

  int tests = 0, fails = 0, reads = 0;
  logic [VPN_W-1:0] last_page;
  logic [PFN_W+3:0] mem [1 << VPN_W];

  always #(CLK_P/2) clk = ~clk;

  page_xlate #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .busy(busy), .done(done),
    .fault(fault), .pa_ok(pa_ok), .paddr(paddr), .pt_req(pt_req),
    .pt_page(pt_page), .pt_rsp_valid(pt_rsp_valid), .pt_rsp_pte(pt_rsp_pte));

  initial begin
    forever begin
      @(negedge clk);
      if (pt_req && !pt_rsp_valid) begin
        reads++;
        last_page = pt_page;
        repeat (2) @(negedge clk);
        pt_rsp_pte = mem[pt_page];
        pt_rsp_valid = 1;
        @(negedge clk);
        pt_rsp_valid = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [VPN_W-1:0] pg, input logic [OFF_W-1:0] of,
                       input logic [1:0] acc, output logic [PA_W-1:0] pa,
                       output logic flt, output logic ok, output int rd, output int cyc);
    int r0;
    r0 = reads;
    @(negedge clk);
    req_vaddr = {pg, of};
    req_acc = acc;
    req_valid = 1;
    cyc = 0;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    pa = paddr; flt = fault; ok = pa_ok;
    rd = reads - r0;
  endtask

  // run one access and check outcome; exp_rd: expected table reads (0 hit, 1 miss)
  task automatic access(input string tag, input logic [VPN_W-1:0] pg, input logic [OFF_W-1:0] of,
                        input logic [1:0] acc, input logic [PFN_W-1:0] frame,
                        input logic exp_flt, input int exp_rd);
    logic [PA_W-1:0] pa; logic flt, ok; int rd, cyc;
    xlate(pg, of, acc, pa, flt, ok, rd, cyc);
    chk({tag, " fault"}, 32'(flt), 32'(exp_flt));
    chk({tag, " pa_ok"}, 32'(ok), 32'(!exp_flt));
    chk({tag, " paddr"}, 32'(pa), exp_flt ? 32'h0 : 32'({frame, of}));
    chk({tag, " reads"}, 32'(rd), 32'(exp_rd));
    if (exp_rd == 0) chk({tag, " hit latency"}, 32'(cyc), 32'd1);
    else chk({tag, " table page"}, 32'(last_page), 32'(pg));
  endtask

  task automatic t_reset;
    chk("R12 done", 32'(done), 0);
    chk("R12 pa_ok", 32'(pa_ok), 0);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 pt_req", 32'(pt_req), 0);
  endtask

  task automatic t_map;
    access("R1 R2 page0 miss", 0, 12'h123, 2'b00, 5, 0, 1);
    access("R3 page0 hit", 0, 12'hABC, 2'b00, 5, 0, 0);
    access("R1 page1", 1, 12'h000, 2'b00, 6, 0, 1);
    access("R1 R5 page2 write", 2, 12'hFFF, 2'b01, 1, 0, 1);
    access("R1 R6 page3 fetch", 3, 12'h555, 2'b10, 2, 0, 1);
  endtask

  task automatic t_perm;
    access("R5 write no-w", 1, 12'h010, 2'b01, 6, 1, 0);
    access("R6 fetch no-x", 1, 12'h010, 2'b10, 6, 1, 0);
    access("R6 read no-r", 3, 12'h020, 2'b00, 2, 1, 0);
    access("R6 read code 11", 2, 12'h030, 2'b11, 1, 0, 0);
    access("R5 write ok", 2, 12'h040, 2'b01, 1, 0, 0);
    access("R6 fetch ok", 0, 12'h050, 2'b10, 5, 0, 0);
  endtask

  task automatic t_invalid_rr;
    access("R4 R7 invalid page", 4, 12'h777, 2'b00, 0, 1, 1);
    access("R8 invalid kept", 4, 12'h001, 2'b01, 0, 1, 0);
    access("R9 page0 evicted", 0, 12'h002, 2'b00, 5, 0, 1);
    access("R9 page2 kept", 2, 12'h003, 2'b00, 1, 0, 0);
    access("R9 page1 evicted", 1, 12'h004, 2'b00, 6, 0, 1);
    access("R9 page2 evicted", 2, 12'h005, 2'b00, 1, 0, 1);
    access("R9 page4 still in", 4, 12'h006, 2'b00, 0, 1, 0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    access("R10 after flush", 4, 12'h008, 2'b00, 0, 1, 1);
    access("R10 page1 after flush", 1, 12'h009, 2'b00, 6, 0, 1);
  endtask

  task automatic t_busy;
    int r0, n;
    r0 = reads;
    @(negedge clk);
    req_vaddr = {8'd5, 12'h0AA}; req_acc = 2'b00; req_valid = 1;
    @(negedge clk);
    chk("R11 busy", 32'(busy), 1);
    req_vaddr = {8'd6, 12'h0BB};
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk("R11 paddr of first", 32'(paddr), 32'({8'h25, 12'h0AA}));
    repeat (3) begin
      @(negedge clk);
      chk("R11 no extra done", 32'(done), 0);
      chk("R11 no extra read", 32'(pt_req), 0);
    end
    chk("R11 read count", 32'(reads - r0), 1);
    access("R11 page6 not installed", 6, 12'h0BB, 2'b00, 8'h26, 0, 1);
  endtask

  initial begin
    for (int i = 0; i < (1 << VPN_W); i++) mem[i] = '0;
    mem[0] = {8'd5, 4'b1111};
    mem[1] = {8'd6, 4'b1001};
    mem[2] = {8'd1, 4'b1011};
    mem[3] = {8'd2, 4'b1100};
    mem[4] = {8'd9, 4'b0111};
    for (int i = 5; i < 10; i++) mem[i] = {8'(8'h20 + i), 4'b1001};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_map();
    t_perm();
    t_invalid_rr();
    t_flush();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule